// File: doc/BRIEF.md
# Addressed Serial Command Parser

This block sits behind a serial byte receiver in a display tile that is chained with other tiles. Each byte comes in with a one-cycle valid strobe. The block decodes command packets that carry a recipient ID. The first byte of a packet names the tile, the target memory space and the direction. The second byte sets the low part of the start address. Every byte after that is one payload access to the chosen space.

Writes to the local register space land in a 16 x 8-bit register file. The register file also holds the tile's own ID, the stride settings and the upper address bits. Accesses to every other space leave through a generic memory port that carries a space code, a 21-bit address, write data, a write strobe and a read request. Read data returns on a response output with a valid strobe.

The running address normally steps by one per payload byte. A programmed stride can be added after every N bytes. With the stride, one packet can fill a rectangular window, or it can cycle over a small group of registers. A packet addressed to another tile is skipped until the packet-end input brings the parser back to idle.

Top module: `pkt_cmd_decoder`

## Requirements
- R1: After a synchronous active-low reset, mem_we, mem_re and rsp_valid are low and the parser waits for a header byte. Register 3 holds the RST_UNIT_ID parameter and every other register holds zero; regs_out carries register k in bits [8k+7:8k].
- R2: The header byte is laid out as follows. Bits [2:0] hold the space code, bit 3 is the write flag (1 = write) and bits [7:4] hold the recipient ID. A header is accepted when its ID equals register 3 bits [3:0] or equals 15 (broadcast).
- R3: If a header is not accepted, the parser ignores every following byte. It issues no memory strobe, no response and no register change until pkt_end is seen.
- R4: The byte after an accepted header sets the start address. Address bits [7:0] take the byte, bits [15:8] are zero and bits [20:16] take register 6 bits [4:0] as they stand when the byte arrives.
- R5: A write payload byte to space 0 stores the byte in the register selected by address bits [3:0]. The new value shows on regs_out one cycle after the byte. No memory strobe is issued.
- R6: A write payload byte to spaces 1, 2, 3, 4, 5 or 7 raises mem_we for one cycle, one cycle after the byte. During that cycle mem_space holds the space code, mem_addr holds the current address and mem_wdata holds the byte.
- R7: The address grows by one per payload byte. When register 4 holds N ≠ 0, every Nth payload byte of a packet also adds register 5, read as a signed 8-bit value, to the address. When register 4 is zero, no stride is added.
- R8: A read payload byte to space 0 raises rsp_valid one cycle later, with rsp_data equal to the register selected by address bits [3:0]. The value of the payload byte has no effect.
- R9: A read payload byte to spaces 1, 2, 3, 4, 5 or 7 raises mem_re for one cycle, one cycle after the byte, with mem_space and mem_addr set. A mem_rvalid pulse with mem_rdata shows on rsp_valid and rsp_data one cycle later.
- R10: When the header ID is 15, read payload bytes raise neither mem_re nor rsp_valid. Writes are still carried out.
- R11: Payload bytes to space 6 are consumed and still advance the address. They raise no strobe and change no register.
- R12: pkt_end returns the parser to idle from any state, and the next byte is taken as a header. A byte that arrives in the same cycle as pkt_end is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | rx_byte is valid this cycle |
| pkt_end | input | 1 | Frame boundary, forces the parser to idle |
| mem_rdata | input | 8 | Read data from the external spaces |
| mem_rvalid | input | 1 | mem_rdata is valid this cycle |
| mem_space | output | 3 | Space code of the current memory access |
| mem_addr | output | 21 | Address of the current memory access |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | One-cycle write strobe |
| mem_re | output | 1 | One-cycle read request |
| rsp_data | output | 8 | Response byte |
| rsp_valid | output | 1 | rsp_data is valid this cycle |
| regs_out | output | 128 | Register file contents, register k in bits [8k+7:8k] |

## Verification
Every effect of a payload byte is due exactly one clock edge after the byte is presented. This covers the memory strobes, the address, the write data, the register-file update and the response to a register read. A returned memory read appears on the response one edge after mem_rvalid. The bench drives each byte on a falling edge and drops it after one cycle. It then compares all outputs at the next falling edge against a bench model that was stepped for that byte. Because the next byte is driven only after that comparison, each result is tied to the byte that caused it, and register writes and the stride settings take effect from the following byte on.

// File: rtl/cmdp_pkg.sv
// Shared types for the addressed command parser.
// Assumes an 8-bit byte stream and a 16-entry register file.
package cmdp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_ADDR = 2'd2,
        ST_DROP = 2'd3
    } cmdp_state_t;

    typedef enum logic [2:0] {
        SP_REG   = 3'd0,
        SP_FB    = 3'd1,
        SP_SRAM  = 3'd2,
        SP_FLASH = 3'd3,
        SP_I2C   = 3'd4,
        SP_GAMMA = 3'd5,
        SP_RSVD  = 3'd6,
        SP_CMD   = 3'd7
    } cmdp_space_t;

    typedef struct packed {
        cmdp_space_t space;
        logic        wr;
        logic        bcast;
    } cmdp_hdr_t;

    localparam int REG_UNIT_ID  = 3;
    localparam int REG_STEP_LEN = 4;
    localparam int REG_STEP_ADJ = 5;
    localparam int REG_ADDR_HI  = 6;

endpackage

// File: rtl/cmdp_rx_fsm.sv
// Receive sequencer: decodes the header byte, filters on the unit ID and
// tracks the header, address and payload phases of a packet.
// Assumes the ID field sits directly above the write flag in the header.
module cmdp_rx_fsm
    import cmdp_pkg::*;
#(
    parameter int ID_W     = 4,
    parameter int BCAST_ID = 15
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_valid,
    input  logic [7:0]      rx_byte,
    input  logic            pkt_end,
    input  logic [ID_W-1:0] local_id,
    output cmdp_state_t     state,
    output cmdp_hdr_t       hdr,
    output logic            addr_load,
    output logic            pay_stb
);
    localparam int ID_LSB = 4;

    logic [ID_W-1:0] rx_id;
    logic            id_hit;
    logic            id_bcast;
    logic            take;

    // Decode the ID field of the byte on the input.
    always_comb begin
        rx_id     = rx_byte[ID_LSB +: ID_W];
        id_bcast  = (rx_id == ID_W'(BCAST_ID));
        id_hit    = id_bcast || (rx_id == local_id);
        take      = rx_valid && !pkt_end;
        addr_load = take && (state == ST_HDR);
        pay_stb   = take && (state == ST_ADDR);
    end

    // Step through the packet phases and latch the header.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            hdr   <= '0;
        end else if (pkt_end) begin
            state <= ST_IDLE;
        end else if (rx_valid) begin
            case (state)
                ST_IDLE: begin
                    if (id_hit) begin
                        state     <= ST_HDR;
                        hdr.space <= cmdp_space_t'(rx_byte[2:0]);
                        hdr.wr    <= rx_byte[3];
                        hdr.bcast <= id_bcast;
                    end else begin
                        state <= ST_DROP;
                    end
                end
                ST_HDR:  state <= ST_ADDR;
                ST_ADDR: state <= ST_ADDR;
                default: state <= ST_DROP;
            endcase
        end
    end

endmodule

// File: rtl/cmdp_addr_gen.sv
// Running address generator: loads the start address, steps by one per
// payload byte and adds a signed stride after every STEP_LEN bytes.
// Assumes step_len and step_adj may change between bytes.
module cmdp_addr_gen #(
    parameter int ADDR_W = 21,
    parameter int LOW_W  = 8,
    parameter int HI_W   = 5,
    parameter int CNT_W  = 8,
    parameter int ADJ_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [LOW_W-1:0]  low_addr,
    input  logic [HI_W-1:0]   hi_addr,
    input  logic              pay_stb,
    input  logic [CNT_W-1:0]  step_len,
    input  logic [ADJ_W-1:0]  step_adj,
    output logic [ADDR_W-1:0] cur_addr
);
    localparam int MID_W = ADDR_W - HI_W - LOW_W;

    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] adj_ext;
    logic              at_edge;

    // Sign-extend the stride and detect the Nth byte.
    always_comb begin
        adj_ext = {{(ADDR_W-ADJ_W){step_adj[ADJ_W-1]}}, step_adj};
        at_edge = (step_len != '0) && (cnt_q == step_len - CNT_W'(1));
    end

    // Hold the address and the byte count within the current stride run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            cnt_q    <= '0;
        end else if (addr_load) begin
            cur_addr <= {hi_addr, {MID_W{1'b0}}, low_addr};
            cnt_q    <= '0;
        end else if (pay_stb) begin
            if (at_edge) begin
                cur_addr <= cur_addr + ADDR_W'(1) + adj_ext;
                cnt_q    <= '0;
            end else begin
                cur_addr <= cur_addr + ADDR_W'(1);
                cnt_q    <= cnt_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/cmdp_regfile.sv
// Local register file: one write port, one asynchronous read port and a
// flat view of all entries. Assumes the ID register resets to RST_ID.
module cmdp_regfile
    import cmdp_pkg::*;
#(
    parameter int NUM    = 16,
    parameter int DW     = 8,
    parameter int RST_ID = 0,
    localparam int IDX_W = $clog2(NUM)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DW-1:0]     wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DW-1:0]     rd_data,
    output logic [NUM*DW-1:0] regs_flat
);
    logic [DW-1:0] regs_q [NUM];

    // Reset to defaults, otherwise store one byte per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM; i++) begin
                regs_q[i] <= (i == REG_UNIT_ID) ? DW'(RST_ID) : '0;
            end
        end else if (wr_en) begin
            regs_q[wr_idx] <= wr_data;
        end
    end

    // Read the selected entry.
    always_comb rd_data = regs_q[rd_idx];

    for (genvar g = 0; g < NUM; g++) begin : g_flat
        assign regs_flat[g*DW +: DW] = regs_q[g];
    end

endmodule

// File: rtl/pkt_cmd_decoder.sv
// Addressed command parser top: joins the sequencer, the address generator
// and the register file, and registers the memory port and the response.
// Assumes upstream presents at most one byte per cycle, and that mem_rvalid
// does not arrive in a cycle where a register read answers.
module pkt_cmd_decoder
    import cmdp_pkg::*;
#(
    parameter int NUM_REGS    = 16,
    parameter int ADDR_W      = 21,
    parameter int ID_W        = 4,
    parameter int HI_W        = 5,
    parameter int BCAST_ID    = 15,
    parameter int RST_UNIT_ID = 0,
    localparam int DW         = 8,
    localparam int IDX_W      = $clog2(NUM_REGS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DW-1:0]        rx_byte,
    input  logic                 rx_valid,
    input  logic                 pkt_end,
    input  logic [DW-1:0]        mem_rdata,
    input  logic                 mem_rvalid,
    output logic [2:0]           mem_space,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [DW-1:0]        mem_wdata,
    output logic                 mem_we,
    output logic                 mem_re,
    output logic [DW-1:0]        rsp_data,
    output logic                 rsp_valid,
    output logic [NUM_REGS*DW-1:0] regs_out
);
    cmdp_state_t       state;
    cmdp_hdr_t         hdr;
    logic              addr_load;
    logic              pay_stb;
    logic [ADDR_W-1:0] cur_addr;
    logic [DW-1:0]     reg_rd_data;
    logic              hdr_bcast;
    logic              in_drop;
    logic              is_reg, is_ext;
    logic              reg_wr, ext_wr, reg_rd, ext_rd;

    cmdp_rx_fsm #(.ID_W(ID_W), .BCAST_ID(BCAST_ID)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .pkt_end   (pkt_end),
        .local_id  (regs_out[REG_UNIT_ID*DW +: ID_W]),
        .state     (state),
        .hdr       (hdr),
        .addr_load (addr_load),
        .pay_stb   (pay_stb)
    );

    cmdp_addr_gen #(.ADDR_W(ADDR_W), .LOW_W(DW), .HI_W(HI_W),
                    .CNT_W(DW), .ADJ_W(DW)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_load (addr_load),
        .low_addr  (rx_byte),
        .hi_addr   (regs_out[REG_ADDR_HI*DW +: HI_W]),
        .pay_stb   (pay_stb),
        .step_len  (regs_out[REG_STEP_LEN*DW +: DW]),
        .step_adj  (regs_out[REG_STEP_ADJ*DW +: DW]),
        .cur_addr  (cur_addr)
    );

    cmdp_regfile #(.NUM(NUM_REGS), .DW(DW), .RST_ID(RST_UNIT_ID)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .wr_idx    (cur_addr[IDX_W-1:0]),
        .wr_data   (rx_byte),
        .rd_idx    (cur_addr[IDX_W-1:0]),
        .rd_data   (reg_rd_data),
        .regs_flat (regs_out)
    );

    // Classify the payload byte by space and direction.
    always_comb begin
        hdr_bcast = hdr.bcast;
        in_drop   = (state == ST_DROP);
        is_reg    = (hdr.space == SP_REG);
        is_ext    = !is_reg && (hdr.space != SP_RSVD);
        reg_wr    = pay_stb && hdr.wr && is_reg;
        ext_wr    = pay_stb && hdr.wr && is_ext;
        reg_rd    = pay_stb && !hdr.wr && is_reg && !hdr.bcast;
        ext_rd    = pay_stb && !hdr.wr && is_ext && !hdr.bcast;
    end

    // Register the memory port; address and data hold between accesses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_re    <= 1'b0;
            mem_space <= '0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= ext_wr;
            mem_re <= ext_rd;
            if (ext_wr || ext_rd) begin
                mem_space <= hdr.space;
                mem_addr  <= cur_addr;
            end
            if (ext_wr) mem_wdata <= rx_byte;
        end
    end

    // Register the response from either a register read or the memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= reg_rd || mem_rvalid;
            if (reg_rd)          rsp_data <= reg_rd_data;
            else if (mem_rvalid) rsp_data <= mem_rdata;
        end
    end

endmodule

// File: rtl/pkt_cmd_decoder_chk.sv
// Property checker for the command parser, attached to every instance.
module pkt_cmd_decoder_chk #(
    parameter int REGS_W = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic              pkt_end,
    input logic              mem_we,
    input logic              mem_re,
    input logic [2:0]        mem_space,
    input logic              hdr_bcast,
    input logic              in_drop,
    input logic [REGS_W-1:0] regs_out
);
    // R6
    we_re_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R11
    rsvd_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> (mem_space != 3'd6));

    // R12
    end_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |=> (!mem_we && !mem_re));

    // R3
    drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_drop |=> (!mem_we && !mem_re && $stable(regs_out)));

    // R10
    bcast_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_bcast && rx_valid) |=> !mem_re);

    // R9
    read_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> $past(rx_valid));

    // R5
    reg_change_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_out) |-> $past(rx_valid));

endmodule

bind pkt_cmd_decoder pkt_cmd_decoder_chk #(.REGS_W(NUM_REGS*8)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .pkt_end   (pkt_end),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_space (mem_space),
    .hdr_bcast (hdr_bcast),
    .in_drop   (in_drop),
    .regs_out  (regs_out)
);

// File: tb/pkt_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module pkt_cmd_decoder_tb_top;
    localparam int RST_ID = 9;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   rx_byte = '0;
    logic         rx_valid = 1'b0;
    logic         pkt_end = 1'b0;
    logic [7:0]   mem_rdata = '0;
    logic         mem_rvalid = 1'b0;
    logic [2:0]   mem_space;
    logic [20:0]  mem_addr;
    logic [7:0]   mem_wdata;
    logic         mem_we, mem_re;
    logic [7:0]   rsp_data;
    logic         rsp_valid;
    logic [127:0] regs_out;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    // Bench model state
    int          m_state = 0;
    logic [2:0]  m_space;
    bit          m_wr, m_bc;
    logic [20:0] m_addr;
    logic [7:0]  m_cnt;
    logic [7:0]  m_regs [16];

    always #4 clk = ~clk;

    pkt_cmd_decoder #(.RST_UNIT_ID(RST_ID)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .pkt_end(pkt_end), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
        .mem_space(mem_space), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .rsp_data(rsp_data),
        .rsp_valid(rsp_valid), .regs_out(regs_out)
    );

    function automatic logic [127:0] exp_flat();
        logic [127:0] f;
        for (int i = 0; i < 16; i++) f[i*8 +: 8] = m_regs[i];
        return f;
    endfunction

    function automatic bit is_ext(input logic [2:0] sp);
        return (sp != 3'd0) && (sp != 3'd6);
    endfunction

    task automatic compare(input string tag, input logic e_we, input logic e_re,
                           input logic e_rv, input logic [20:0] e_addr,
                           input logic [2:0] e_sp, input logic [7:0] e_wd,
                           input logic [7:0] e_rd);
        bit bad = 0;
        vectors++;
        if (mem_we !== e_we || mem_re !== e_re || rsp_valid !== e_rv) bad = 1;
        if ((e_we || e_re) && (mem_addr !== e_addr || mem_space !== e_sp)) bad = 1;
        if (e_we && mem_wdata !== e_wd) bad = 1;
        if (e_rv && rsp_data !== e_rd) bad = 1;
        if (regs_out !== exp_flat()) bad = 1;
        if (bad) begin
            fails++;
            $display("FAIL %s: got we=%0b re=%0b rv=%0b addr=%h sp=%0d wd=%h rd=%h regs=%h | exp we=%0b re=%0b rv=%0b addr=%h sp=%0d wd=%h rd=%h regs=%h",
                     tag, mem_we, mem_re, rsp_valid, mem_addr, mem_space, mem_wdata,
                     rsp_data, regs_out, e_we, e_re, e_rv, e_addr, e_sp, e_wd, e_rd,
                     exp_flat());
        end
    endtask

    // Present one byte, step the model, check one cycle later.
    task automatic send(input logic [7:0] b, input string tag);
        logic e_we = 0, e_re = 0, e_rv = 0;
        logic [20:0] e_addr = '0;
        logic [2:0]  e_sp = '0;
        logic [7:0]  e_wd = '0, e_rd = '0;
        logic [20:0] a;
        bit          do_w = 0;
        case (m_state)
            0: begin
                if (b[7:4] == m_regs[3][3:0] || b[7:4] == 4'd15) begin
                    m_state = 1; m_space = b[2:0]; m_wr = b[3]; m_bc = (b[7:4] == 4'd15);
                end else m_state = 3;
            end
            1: begin
                m_addr = {m_regs[6][4:0], 8'h00, b}; m_cnt = 0; m_state = 2;
            end
            2: begin
                a = m_addr;
                if (m_wr) begin
                    if (m_space == 3'd0) do_w = 1;
                    else if (is_ext(m_space)) begin
                        e_we = 1; e_addr = a; e_sp = m_space; e_wd = b;
                    end
                end else if (!m_bc) begin
                    if (m_space == 3'd0) begin e_rv = 1; e_rd = m_regs[a[3:0]]; end
                    else if (is_ext(m_space)) begin e_re = 1; e_addr = a; e_sp = m_space; end
                end
                if (m_regs[4] != 0 && m_cnt == m_regs[4] - 8'd1) begin
                    m_addr = a + 21'd1 + {{13{m_regs[5][7]}}, m_regs[5]}; m_cnt = 0;
                end else begin
                    m_addr = a + 21'd1; m_cnt = m_cnt + 8'd1;
                end
                if (do_w) m_regs[a[3:0]] = b;
            end
            default: ;
        endcase
        @(negedge clk); rx_byte = b; rx_valid = 1;
        @(negedge clk); rx_valid = 0;
        compare(tag, e_we, e_re, e_rv, e_addr, e_sp, e_wd, e_rd);
    endtask

    task automatic end_pkt(input string tag);
        @(negedge clk); pkt_end = 1;
        @(negedge clk); pkt_end = 0;
        m_state = 0;
        compare(tag, 0, 0, 0, '0, '0, '0, '0);
    endtask

    task automatic end_with_byte(input logic [7:0] b, input string tag);
        @(negedge clk); pkt_end = 1; rx_valid = 1; rx_byte = b;
        @(negedge clk); pkt_end = 0; rx_valid = 0;
        m_state = 0;
        compare(tag, 0, 0, 0, '0, '0, '0, '0);
    endtask

    task automatic mem_reply(input logic [7:0] d, input string tag);
        mem_rdata = d; mem_rvalid = 1;
        @(negedge clk); mem_rvalid = 0;
        compare(tag, 0, 0, 1, '0, '0, '0, d);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) m_regs[i] = (i == 3) ? 8'(RST_ID) : 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        compare("R1 reset", 0, 0, 0, '0, '0, '0, '0);

        // R5: register writes, reg6 sets upper address
        send(8'h98, "R2 hdr"); send(8'h06, "R4 addr");
        send(8'h02, "R5 wr reg6"); send(8'hAB, "R5 wr reg7");
        end_pkt("R12 end");

        // R6 / R4: SRAM writes with upper bits from reg6
        send(8'h9A, "R2 hdr"); send(8'h10, "R4 addr");
        send(8'h11, "R6 wr"); send(8'h22, "R6 wr"); send(8'h33, "R6 wr");
        end_pkt("R12 end");

        // R7: stride 3, -4 over framebuffer
        send(8'h98, "R2 hdr"); send(8'h04, "R4 addr");
        send(8'h03, "R5 len"); send(8'hFC, "R5 adj");
        end_pkt("R12 end");
        send(8'h99, "R2 hdr"); send(8'h20, "R4 addr");
        for (int i = 0; i < 7; i++) send(8'(i + 1), "R7 stride");
        end_pkt("R12 end");

        // R8: register reads ignore payload value
        send(8'h90, "R2 hdr"); send(8'h04, "R4 addr");
        send(8'hFF, "R8 rd"); send(8'h00, "R8 rd"); send(8'h5C, "R8 rd");
        end_pkt("R12 end");

        // R7: reg group sweep, len 2 adj -2 on register reads
        send(8'h98, "R2 hdr"); send(8'h04, "R4 addr");
        send(8'h02, "R5 len"); send(8'hFE, "R5 adj");
        end_pkt("R12 end");
        send(8'h90, "R2 hdr"); send(8'h06, "R4 addr");
        for (int i = 0; i < 6; i++) send(8'h00, "R7 sweep");
        end_pkt("R12 end");

        // R7: stride disabled
        send(8'h98, "R2 hdr"); send(8'h04, "R4 addr"); send(8'h00, "R5 len");
        end_pkt("R12 end");
        send(8'h9B, "R2 hdr"); send(8'hFE, "R4 addr");
        for (int i = 0; i < 4; i++) send(8'(8'h40 + i), "R7 no stride");
        end_pkt("R12 end");

        // R9: external read and returned data
        send(8'h93, "R2 hdr"); send(8'h40, "R4 addr"); send(8'h00, "R9 rd");
        mem_reply(8'hC3, "R9 reply");
        end_pkt("R12 end");

        // R10: broadcast write, broadcast reads suppressed
        send(8'hF8, "R10 bc hdr"); send(8'h08, "R4 addr"); send(8'h5A, "R10 bc wr");
        end_pkt("R12 end");
        send(8'hF0, "R10 bc hdr"); send(8'h08, "R4 addr"); send(8'h00, "R10 bc reg rd");
        end_pkt("R12 end");
        send(8'hF2, "R10 bc hdr"); send(8'h08, "R4 addr"); send(8'h00, "R10 bc mem rd");
        end_pkt("R12 end");

        // R3: other unit ignored
        send(8'h3A, "R3 hdr"); send(8'h00, "R3 skip"); send(8'h55, "R3 skip");
        end_pkt("R12 end");
        send(8'h38, "R3 hdr"); send(8'h01, "R3 skip"); send(8'h77, "R3 skip");
        end_pkt("R12 end");

        // R11: reserved space
        send(8'h9E, "R2 hdr"); send(8'h00, "R4 addr");
        send(8'h66, "R11 rsvd"); send(8'h67, "R11 rsvd");
        end_pkt("R12 end");

        // R12: end mid-packet and end with a byte
        send(8'h9A, "R2 hdr"); end_pkt("R12 mid");
        send(8'h9A, "R12 new hdr"); end_with_byte(8'h00, "R12 drop");
        send(8'h9A, "R12 hdr after"); send(8'h01, "R4 addr"); send(8'hEE, "R6 wr");
        end_pkt("R12 end");

        // R2: change own ID
        send(8'h98, "R2 hdr"); send(8'h03, "R4 addr"); send(8'h04, "R5 id");
        end_pkt("R12 end");
        send(8'h9A, "R2 old id"); send(8'h00, "R3 skip"); send(8'h01, "R3 skip");
        end_pkt("R12 end");
        send(8'h4A, "R2 new id"); send(8'h00, "R4 addr"); send(8'h01, "R6 wr");
        end_pkt("R12 end");

        // Random packets
        void'($urandom(32'd4242));
        for (int p = 0; p < 300; p++) begin
            int sel = $urandom % 4;
            logic [3:0] id;
            logic [2:0] sp = 3'($urandom);
            bit wr = 1'($urandom);
            int n = 1 + ($urandom % 8);
            id = (sel == 1) ? 4'd15 : (sel == 2) ? 4'($urandom) : m_regs[3][3:0];
            send({id, wr, sp}, "R2 rand hdr");
            send(8'($urandom), "R4 rand addr");
            for (int k = 0; k < n; k++) send(8'($urandom), "R7 rand pay");
            end_pkt("R12 rand end");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule